// File: doc/BRIEF.md
# Amplitude-Modulated Triangle Carrier PWM Generator

This block drives the two device groups of a single-phase full-bridge inverter with unipolar gating pulses. A sinusoidal reference, scaled by a modulation index, is compared with a triangular carrier. The carrier's peak does not stay fixed: it rises and falls with the magnitude of the same sine sample that forms the reference. Because of this, the output voltage keeps a linear relation to the index up to the square-wave limit.

A single quarter-wave table of sine magnitudes feeds both paths. A sequencer walks the table forward and then backward, and it marks the second half of each cycle as negative. The rest of the fundamental period is rebuilt this way. The carrier is an up/down counter. The sine phase steps once every fixed number of carrier steps, so the carrier frequency is always an integer multiple of the reference frequency. A programmable divider sets how many system clocks make one timebase step. Deasserting the enable input stops all switching and returns the waveform to phase zero.

Top module: `amc_pwm_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, both gate outputs are low after that edge, whatever the other inputs are.
- R2: While enable is low, both gates are low one clock later. The block restarts from phase zero (sample 0, carrier 0, rising) on the first enabled edge.
- R3: The timebase steps once every clk_div+1 clocks. The waveform state changes only on those steps.
- R4: A cycle has 200 samples in four quarters of 50. Within quarter q at offset o, the table address is o for q = 0 and q = 2, and 50-o for q = 1 and q = 3. Samples 100 to 199 are negative. Table entry k is floor(1024·sin(k·1.8°)), clamped to 1023. This gives 0, 32, 160, 575, 677, 724, 1019 and 1023 at k = 0, 1, 5, 19, 23, 25, 47 and 50.
- R5: The carrier counter runs 0,1,…,16,15,…,1 and repeats every 32 steps. The sine phase moves on every 4 steps, so one cycle of 800 steps holds 25 carrier periods.
- R6: The modulated carrier is (counter × |sample|) >> 4.
- R7: The reference is (mod_index × |sample|) >> 10, saturated at 1023. mod_index is unsigned with 10 fractional bits, so 1024 means 1.0.
- R8: In samples 0 to 99, gate_pos is high when the reference is strictly greater than the carrier, and gate_neg is low. In samples 100 to 199 the roles swap. When the sample is zero, both gates are low.
- R9: gate_pos and gate_neg are never high at the same time.
- R10: The gates are registered. The gate pair seen after edge e is computed from the waveform state that held before edge e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run when high; when low, gates are forced off and the phase returns to zero |
| mod_index | input | 12 | Modulation index, unsigned, 10 fractional bits |
| clk_div | input | 8 | Timebase step period minus one, in clocks |
| gate_pos | output | 1 | Gate for the positive device group |
| gate_neg | output | 1 | Gate for the negative device group |

## Verification
The assertions assume that clk_div and mod_index change only while enable is low. If the divider setting changed during a run, the divider count could go past the new limit and wrap. The stimulus only sets these inputs between runs, with enable held low, and then raises enable. Every run therefore starts from phase zero. A scoreboard predicts each timebase step from its own sine computation. It covers a full cycle, several divider settings, a saturating index, a zero index, and a restart part-way through a cycle.

// File: rtl/amc_pkg.sv
// Package amc_pkg
// Shared constants, types and the quarter-wave sine magnitude table.
// Assumes a 1.8 degree step, so there are 50 intervals per quarter.
package amc_pkg;
    localparam int QTR_STEPS = 50;
    localparam int SINE_W    = 11;
    localparam int MAG_W     = 10;
    localparam int ADDR_W    = $clog2(QTR_STEPS + 1);

    typedef logic [SINE_W-1:0] sine_word_t;
    typedef logic [ADDR_W-1:0] qaddr_t;

    // floor(1024*sin(k*1.8 deg)) clamped to 1023; MSB is zero for every entry
    function automatic sine_word_t quarter_sine(input qaddr_t k);
        case (k)
            6'd0:  return 11'd0;    6'd1:  return 11'd32;   6'd2:  return 11'd64;
            6'd3:  return 11'd96;   6'd4:  return 11'd128;  6'd5:  return 11'd160;
            6'd6:  return 11'd191;  6'd7:  return 11'd223;  6'd8:  return 11'd254;
            6'd9:  return 11'd285;  6'd10: return 11'd316;  6'd11: return 11'd346;
            6'd12: return 11'd376;  6'd13: return 11'd406;  6'd14: return 11'd435;
            6'd15: return 11'd464;  6'd16: return 11'd493;  6'd17: return 11'd521;
            6'd18: return 11'd548;  6'd19: return 11'd575;  6'd20: return 11'd601;
            6'd21: return 11'd627;  6'd22: return 11'd652;  6'd23: return 11'd677;
            6'd24: return 11'd700;  6'd25: return 11'd724;  6'd26: return 11'd746;
            6'd27: return 11'd768;  6'd28: return 11'd789;  6'd29: return 11'd809;
            6'd30: return 11'd828;  6'd31: return 11'd846;  6'd32: return 11'd864;
            6'd33: return 11'd881;  6'd34: return 11'd897;  6'd35: return 11'd912;
            6'd36: return 11'd926;  6'd37: return 11'd939;  6'd38: return 11'd952;
            6'd39: return 11'd963;  6'd40: return 11'd973;  6'd41: return 11'd983;
            6'd42: return 11'd991;  6'd43: return 11'd999;  6'd44: return 11'd1005;
            6'd45: return 11'd1011; 6'd46: return 11'd1015; 6'd47: return 11'd1019;
            6'd48: return 11'd1021; 6'd49: return 11'd1023;
            default: return 11'd1023;
        endcase
    endfunction
endpackage

// File: rtl/amc_timebase.sv
// Module amc_timebase
// Produces a one-clock step pulse every div_sel+1 clocks while enabled.
// Assumes div_sel is changed only while enable is low.
module amc_timebase #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = enable && (cnt == div_sel);

    // Divider count: cleared when idle or on each step
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tick) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // R3: with a nonzero divide setting, two steps are never adjacent
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0 && $stable(div_sel)) |=> !tick);
endmodule

// File: rtl/amc_sequencer.sv
// Module amc_sequencer
// Steps the triangle counter and the sine phase on timebase steps, and
// mirrors the quarter-table address. Returns to phase zero when disabled.
module amc_sequencer #(
    parameter int CAR_LOG2 = 4,
    parameter int SUB_LOG2 = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  tick,
    output amc_pkg::qaddr_t       rom_addr,
    output logic                  neg_half,
    output logic [CAR_LOG2:0]     tri_val
);
    import amc_pkg::*;
    localparam logic [CAR_LOG2:0] TRI_TURN = (CAR_LOG2+1)'((1 << CAR_LOG2) - 1);
    localparam logic [CAR_LOG2:0] TRI_ONE  = (CAR_LOG2+1)'(1);
    localparam qaddr_t            OFF_LAST = ADDR_W'(QTR_STEPS - 1);
    localparam qaddr_t            OFF_TOP  = ADDR_W'(QTR_STEPS);

    logic [1:0]          quarter;
    qaddr_t              offset;
    logic [SUB_LOG2-1:0] sub;
    logic                tri_up;
    logic [CAR_LOG2:0]   tri_q;

    // Waveform state: triangle up/down count, sub-step count and sine phase
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            quarter <= '0;
            offset  <= '0;
            sub     <= '0;
            tri_up  <= 1'b1;
            tri_q   <= '0;
        end else if (tick) begin
            if (tri_up) begin
                tri_q <= tri_q + 1'b1;
                if (tri_q == TRI_TURN) tri_up <= 1'b0;
            end else begin
                tri_q <= tri_q - 1'b1;
                if (tri_q == TRI_ONE) tri_up <= 1'b1;
            end
            sub <= sub + 1'b1;
            if (&sub) begin
                if (offset == OFF_LAST) begin
                    offset  <= '0;
                    quarter <= quarter + 1'b1;
                end else begin
                    offset <= offset + 1'b1;
                end
            end
        end
    end

    // Mirror the address in odd quarters; the sign comes from the upper half
    always_comb begin
        rom_addr = quarter[0] ? (OFF_TOP - offset) : offset;
        neg_half = quarter[1];
        tri_val  = tri_q;
    end

    // R5: every step moves the triangle by exactly one count
    assert_tri_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!enable || tri_q == $past(tri_q) + 1'b1 || tri_q + 1'b1 == $past(tri_q)));
    // R3: without a step the waveform state holds
    assert_state_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> ($stable(tri_q) && $stable(offset) && $stable(quarter)));
endmodule

// File: rtl/amc_sine_rom.sv
// Module amc_sine_rom
// Reads the quarter table and applies the sign for the negative half-cycle.
// Purely combinational; assumes addr never exceeds the quarter length.
module amc_sine_rom (
    input  amc_pkg::qaddr_t     addr,
    input  logic                neg_half,
    output amc_pkg::sine_word_t sample
);
    import amc_pkg::*;
    sine_word_t word;

    // Table read followed by two's-complement sign selection
    always_comb begin
        word   = quarter_sine(addr);
        sample = neg_half ? (~word + 1'b1) : word;
    end
endmodule

// File: rtl/amc_modulator.sv
// Module amc_modulator
// Scales the sine magnitude by the index (the reference) and by the triangle
// (the carrier), compares the two and registers one gate per device group.
module amc_modulator #(
    parameter int MI_W     = 12,
    parameter int MI_FRAC  = 10,
    parameter int CAR_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  amc_pkg::sine_word_t sample,
    input  logic [CAR_LOG2:0]   tri_val,
    input  logic [MI_W-1:0]     mod_index,
    output logic                gate_pos,
    output logic                gate_neg
);
    import amc_pkg::*;
    localparam int REF_PW = MI_W + MAG_W;
    localparam int CAR_PW = CAR_LOG2 + 1 + MAG_W;
    localparam logic [REF_PW-1:0] REF_MAX = REF_PW'((1 << MAG_W) - 1);

    logic              sample_neg;
    logic [MAG_W-1:0]  mag;
    logic [REF_PW-1:0] ref_prod, ref_shift;
    logic [MAG_W-1:0]  ref_sat;
    logic [CAR_PW-1:0] car_prod, car_shift;
    logic              active;

    // Magnitude, saturated reference, envelope-scaled carrier and comparison
    always_comb begin
        sample_neg = sample[SINE_W-1];
        mag        = sample_neg ? MAG_W'(~sample + 1'b1) : sample[MAG_W-1:0];
        ref_prod   = REF_PW'(mod_index) * REF_PW'(mag);
        ref_shift  = ref_prod >> MI_FRAC;
        ref_sat    = (ref_shift > REF_MAX) ? REF_MAX[MAG_W-1:0] : ref_shift[MAG_W-1:0];
        car_prod   = CAR_PW'(tri_val) * CAR_PW'(mag);
        car_shift  = car_prod >> CAR_LOG2;
        active     = CAR_PW'(ref_sat) > car_shift;
    end

    // Registered gates: half-cycle sign chooses the device group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_pos <= 1'b0;
            gate_neg <= 1'b0;
        end else begin
            gate_pos <= enable && active && !sample_neg;
            gate_neg <= enable && active && sample_neg;
        end
    end

    // R9: the two device groups are never driven together
    assert_gates_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_pos && gate_neg));
    // R2: a disabled cycle is followed by both gates low
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_pos && !gate_neg));
    // R8: a zero sine sample never produces a pulse
    assert_zero_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample == '0) |=> (!gate_pos && !gate_neg));
endmodule

// File: rtl/amc_pwm_gen.sv
// Module amc_pwm_gen (top)
// Unipolar PWM with a triangle carrier whose peak follows the sine envelope.
// A single quarter-wave table feeds both the reference and the carrier.
// Assumes clk_div and mod_index are changed only while enable is low.
module amc_pwm_gen #(
    parameter int DIV_W    = 8,
    parameter int MI_W     = 12,
    parameter int MI_FRAC  = 10,
    parameter int CAR_LOG2 = 4,
    parameter int SUB_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [MI_W-1:0] mod_index,
    input  logic [DIV_W-1:0] clk_div,
    output logic            gate_pos,
    output logic            gate_neg
);
    import amc_pkg::*;

    logic              tick;
    qaddr_t            rom_addr;
    logic              neg_half;
    logic [CAR_LOG2:0] tri_val;
    sine_word_t        sample;

    amc_timebase #(.DIV_W(DIV_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(clk_div), .tick(tick));

    amc_sequencer #(.CAR_LOG2(CAR_LOG2), .SUB_LOG2(SUB_LOG2)) u_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .rom_addr(rom_addr), .neg_half(neg_half), .tri_val(tri_val));

    amc_sine_rom u_rom (
        .addr(rom_addr), .neg_half(neg_half), .sample(sample));

    amc_modulator #(.MI_W(MI_W), .MI_FRAC(MI_FRAC), .CAR_LOG2(CAR_LOG2)) u_modulator (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample(sample), .tri_val(tri_val),
        .mod_index(mod_index), .gate_pos(gate_pos), .gate_neg(gate_neg));
endmodule

// File: tb/test_amc_pwm_gen.sv
// Scoreboard bench: the driver queues the expected gate pair for each
// timebase step, and the monitor pops and compares once per step.
module test_amc_pwm_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [11:0] mod_index = '0;
    logic [7:0]  clk_div = '0;
    logic        gate_pos, gate_neg;

    always #4 clk = ~clk;

    amc_pwm_gen i_amc_pwm_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mod_index(mod_index),
        .clk_div(clk_div), .gate_pos(gate_pos), .gate_neg(gate_neg));

    typedef struct {
        logic  pos;
        logic  neg;
        int    step;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    failures = 0;
    int    sine_tab[51];
    bit    mon_on = 0;
    int    mon_div = 0;
    int    mon_cnt = 0;

    // R4: table model computed independently from the sine function
    initial begin
        for (int k = 0; k <= 50; k++) begin
            int v;
            v = int'($floor(1024.0 * $sin(k * 3.14159265358979 / 100.0)));
            sine_tab[k] = (v > 1023) ? 1023 : v;
        end
    end

    // Expected gates after step n (R4 R5 R6 R7 R8)
    function automatic void model(input int n, input int m, output logic p, output logic ng);
        int s, q, o, addr, mag, tp, tv, rv, cv;
        bit neg;
        s    = (n / 4) % 200;
        q    = s / 50;
        o    = s % 50;
        addr = (q % 2 == 1) ? 50 - o : o;
        mag  = sine_tab[addr];
        neg  = (q >= 2);
        tp   = n % 32;
        tv   = (tp <= 16) ? tp : 32 - tp;
        rv   = (m * mag) >> 10;
        if (rv > 1023) rv = 1023;
        cv   = (tv * mag) >> 4;
        p    = (rv > cv) && !neg;
        ng   = (rv > cv) && neg;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: samples 2 ns after each edge and pops one item per step
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (mon_cnt % (mon_div + 1) == 0) begin
                if (sb_q.size() == 0) begin
                    check(0, "R10", "scoreboard underflow", 0, 1);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(gate_pos === e.pos && gate_neg === e.neg, e.tag,
                          $sformatf("gates {pos,neg} at step %0d", e.step),
                          {gate_pos, gate_neg}, {e.pos, e.neg});
                    check(!(gate_pos && gate_neg), "R9", "both gates high", 1, 0);
                end
            end
            mon_cnt++;
        end
    end

    // Driver: queues nsteps expected items, then runs until they are consumed
    task automatic run_seg(input int m, input int d, input int nsteps, input string tag);
        @(negedge clk);
        enable    = 1'b0;
        mod_index = 12'(m);
        clk_div   = 8'(d);
        @(negedge clk);
        for (int n = 0; n < nsteps; n++) begin
            exp_t e;
            model(n, m, e.pos, e.neg);
            e.step = n;
            e.tag  = tag;
            sb_q.push_back(e);
        end
        mon_div = d;
        mon_cnt = 0;
        mon_on  = 1;
        enable  = 1'b1;
        wait (sb_q.size() == 0);
        @(negedge clk);
        mon_on = 0;
        enable = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: enable high with a nonzero index, but reset holds the gates low
        enable    = 1'b1;
        mod_index = 12'd1024;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!gate_pos && !gate_neg, "R1", "gates during reset", {gate_pos, gate_neg}, 0);
        end
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R2: disabled after reset, so the gates stay low
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!gate_pos && !gate_neg, "R2", "gates while disabled", {gate_pos, gate_neg}, 0);
        end
        // Full cycle at index 1.0, one step per clock
        run_seg(1024, 0, 820, "R4 R5 R6 R8 R10");
        // Half index, divide by two and by four (R3)
        run_seg(512, 1, 420, "R3 R7");
        run_seg(819, 3, 260, "R3 R8");
        // Saturated index (R7)
        run_seg(4095, 0, 400, "R7 saturation");
        // Zero index: no pulses at all (R7)
        run_seg(0, 0, 220, "R7 zero index");
        // Stop part-way, then restart from phase zero (R2)
        run_seg(700, 0, 130, "R2 partial");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!gate_pos && !gate_neg, "R2", "gates after disable", {gate_pos, gate_neg}, 0);
        end
        run_seg(700, 0, 300, "R2 restart");
        finish_run();
    end
endmodule